// File: doc/BRIEF.md
# Microcontroller Low-Power Mode Controller

This block sequences the sleep states of a small 8-bit microcontroller. Software writes a two-bit control field to request either a light sleep, where only the CPU clock is gated while peripherals keep their clock, or a deep sleep, where the oscillator enable is dropped and every clock stops. The controller turns those requests, together with an enabled-interrupt-pending flag, the external reset pin and an oscillator-stable flag, into clock enables for the CPU and peripherals, an oscillator enable, a one-cycle SFR reset pulse and a RAM write inhibit.

Light sleep ends on an interrupt or on the reset pin. When the reset pin ends light sleep, the CPU keeps running for a fixed window of two machine cycles before the internal reset sequence starts. RAM writes are blocked during that window, but port writes are not. Deep sleep ignores interrupts. Only the reset pin ends it, and the reset sequence starts only once the restarted oscillator reports stable while the pin is still held. The RAM itself is never cleared by the block. The reset sequence reinitialises the control field only.

Top module: `lpm_ctrl`

## Requirements
- R1: After `rst`, the CPU, peripheral and oscillator enables are 1, the RAM inhibit and SFR reset pulse are 0, and `req_bits_o` is 00.
- R2: In run mode, a write with bit 0 set and bit 1 clear enters light sleep on the next cycle: CPU enable 0, peripheral and oscillator enables 1, `req_bits_o` = 01. The block stays in light sleep until it is woken.
- R3: In light sleep, `irq_pend_i` returns the block to run mode on the next cycle. Bit 0 of the control field clears and no SFR reset pulse is produced.
- R4: A write with bit 1 set enters deep sleep on the next cycle: all three enables 0. If bit 0 is also set, deep sleep still wins and `req_bits_o` = 10.
- R5: In deep sleep, `irq_pend_i` has no effect. The enables stay 0 and `req_bits_o` stays 10.
- R6: A reset pin assertion seen in light sleep opens a window of exactly 24 cycles (2 machine cycles of 12 clocks). In that window the CPU enable and RAM inhibit are both 1, so port writes proceed and RAM writes do not. The SFR reset pulse follows in the cycle after the window.
- R7: A reset pin assertion seen in deep sleep raises only the oscillator enable. The block waits for `osc_stable_i`. If the pin drops before the oscillator is stable, the block returns to deep sleep.
- R8: The SFR reset pulse lasts exactly one cycle and clears `req_bits_o`. The CPU enable stays 0 until the cycle after the reset pin is released.
- R9: A reset pin assertion seen in run mode starts the reset sequence on the next cycle, with no RAM-inhibit window.
- R10: Control writes are ignored outside run mode. For example, a deep-sleep write during light sleep leaves `req_bits_o` at 01 and the oscillator enable at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high controller reset |
| hw_rst_i | input | 1 | External reset pin level |
| irq_pend_i | input | 1 | An enabled interrupt is pending |
| osc_stable_i | input | 1 | Oscillator has restarted and is stable |
| ctl_wr_i | input | 1 | Software write strobe for the control field |
| ctl_wdata_i | input | 2 | Write data: bit 0 requests light sleep, bit 1 requests deep sleep |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| sfr_rst_o | output | 1 | One-cycle SFR reinitialisation pulse |
| ram_inh_o | output | 1 | RAM write inhibit |
| req_bits_o | output | 2 | Current control field |

## Verification
The sleep function is exercised with four patterns: a light-sleep-only write, a write with both bits set, interrupts given in each sleep state, and the reset pin asserted from run, light sleep and deep sleep. The combined write tells the priority rule from a plain light sleep. An interrupt during deep sleep separates the two wake policies. The three reset entries tell apart the 24-cycle inhibit window, the direct reset and the oscillator wait. A CPU stub counts port and RAM writes during the window, which shows that RAM writes are blocked while port writes continue. A reset pin pulse that drops before the oscillator is stable shows the fall-back to deep sleep.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        ST_RUN  = 3'd0,
        ST_IDLE = 3'd1,
        ST_RWIN = 3'd2,
        ST_PDN  = 3'd3,
        ST_WAKE = 3'd4,
        ST_RST  = 3'd5
    } lpm_state_e;

    localparam int REQ_IDLE_BIT = 0;
    localparam int REQ_PDN_BIT  = 1;

    typedef struct packed {
        logic cpu_en;
        logic per_en;
        logic osc_en;
        logic ram_inh;
    } clk_ctl_t;

    function automatic clk_ctl_t ctl_for(lpm_state_e s);
        clk_ctl_t c;
        case (s)
            ST_RUN:  c = '{cpu_en: 1'b1, per_en: 1'b1, osc_en: 1'b1, ram_inh: 1'b0};
            ST_IDLE: c = '{cpu_en: 1'b0, per_en: 1'b1, osc_en: 1'b1, ram_inh: 1'b0};
            ST_RWIN: c = '{cpu_en: 1'b1, per_en: 1'b1, osc_en: 1'b1, ram_inh: 1'b1};
            ST_PDN:  c = '{cpu_en: 1'b0, per_en: 1'b0, osc_en: 1'b0, ram_inh: 1'b0};
            ST_WAKE: c = '{cpu_en: 1'b0, per_en: 1'b0, osc_en: 1'b1, ram_inh: 1'b0};
            default: c = '{cpu_en: 1'b0, per_en: 1'b1, osc_en: 1'b1, ram_inh: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lpm_wincnt.sv
module lpm_wincnt #(
    parameter int WIN = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic done_o
);
    localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIN - 1);

    logic [CW-1:0] cnt;
    logic          busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            busy <= 1'b0;
        end else if (start_i) begin
            cnt  <= LAST;
            busy <= 1'b1;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    assign done_o = busy && (cnt == '0);

    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt <= LAST));

    a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
        busy |-> !start_i);

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hw_rst_i,
    input  logic       irq_pend_i,
    input  logic       osc_stable_i,
    input  logic       ctl_wr_i,
    input  logic [1:0] ctl_wdata_i,
    input  logic       win_done_i,
    output lpm_state_e state_o,
    output logic [1:0] req_bits_o,
    output logic       win_start_o,
    output logic       sfr_pulse_o
);
    lpm_state_e state, nxt;
    logic [1:0] bits;
    logic       pulse;

    always_comb begin
        nxt = state;
        case (state)
            ST_RUN: begin
                if (hw_rst_i)                               nxt = ST_RST;
                else if (ctl_wr_i && ctl_wdata_i[REQ_PDN_BIT])  nxt = ST_PDN;
                else if (ctl_wr_i && ctl_wdata_i[REQ_IDLE_BIT]) nxt = ST_IDLE;
            end
            ST_IDLE: begin
                if (hw_rst_i)        nxt = ST_RWIN;
                else if (irq_pend_i) nxt = ST_RUN;
            end
            ST_RWIN: if (win_done_i) nxt = ST_RST;
            ST_PDN:  if (hw_rst_i)   nxt = ST_WAKE;
            ST_WAKE: begin
                if (!hw_rst_i)         nxt = ST_PDN;
                else if (osc_stable_i) nxt = ST_RST;
            end
            default: if (!hw_rst_i) nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RUN;
            bits  <= 2'b00;
            pulse <= 1'b0;
        end else begin
            state <= nxt;
            pulse <= (nxt == ST_RST) && (state != ST_RST);
            if (nxt == ST_RST || (state == ST_IDLE && nxt != ST_IDLE))
                bits <= 2'b00;
            else if (state == ST_RUN && ctl_wr_i)
                bits <= ctl_wdata_i[REQ_PDN_BIT] ? 2'b10 : ctl_wdata_i;
        end
    end

    assign state_o     = state;
    assign req_bits_o  = bits;
    assign win_start_o = (state == ST_IDLE) && hw_rst_i;
    assign sfr_pulse_o = pulse;

    a_r4_pdn_priority: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !hw_rst_i && ctl_wr_i && ctl_wdata_i == 2'b11) |=> (state == ST_PDN));

    a_r5_irq_no_wake: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PDN && !hw_rst_i) |=> (state == ST_PDN));

    a_r7_wait_stable: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAKE && !osc_stable_i) |=> (state != ST_RST));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

    a_r10_idle_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !hw_rst_i && !irq_pend_i) |=> $stable(bits));

endmodule

// File: rtl/lpm_outdec.sv
module lpm_outdec
    import lpm_pkg::*;
(
    input  lpm_state_e state_i,
    output logic       cpu_en_o,
    output logic       per_en_o,
    output logic       osc_en_o,
    output logic       ram_inh_o
);
    clk_ctl_t c;

    always_comb c = ctl_for(state_i);

    assign cpu_en_o  = c.cpu_en;
    assign per_en_o  = c.per_en;
    assign osc_en_o  = c.osc_en;
    assign ram_inh_o = c.ram_inh;

    always_comb begin
        a_r2_per_needs_osc: assert (!c.per_en || c.osc_en);
    end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int CLK_PER_MC = 12,
    parameter int WIN_MC     = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hw_rst_i,
    input  logic       irq_pend_i,
    input  logic       osc_stable_i,
    input  logic       ctl_wr_i,
    input  logic [1:0] ctl_wdata_i,
    output logic       cpu_clk_en_o,
    output logic       per_clk_en_o,
    output logic       osc_en_o,
    output logic       sfr_rst_o,
    output logic       ram_inh_o,
    output logic [1:0] req_bits_o
);
    localparam int WIN = CLK_PER_MC * WIN_MC;

    lpm_state_e state;
    logic       win_start, win_done;

    lpm_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .hw_rst_i     (hw_rst_i),
        .irq_pend_i   (irq_pend_i),
        .osc_stable_i (osc_stable_i),
        .ctl_wr_i     (ctl_wr_i),
        .ctl_wdata_i  (ctl_wdata_i),
        .win_done_i   (win_done),
        .state_o      (state),
        .req_bits_o   (req_bits_o),
        .win_start_o  (win_start),
        .sfr_pulse_o  (sfr_rst_o)
    );

    lpm_wincnt #(.WIN(WIN)) u_win (
        .clk     (clk),
        .rst     (rst),
        .start_i (win_start),
        .done_o  (win_done)
    );

    lpm_outdec u_dec (
        .state_i   (state),
        .cpu_en_o  (cpu_clk_en_o),
        .per_en_o  (per_clk_en_o),
        .osc_en_o  (osc_en_o),
        .ram_inh_o (ram_inh_o)
    );

    a_r6_window_then_pulse: assert property (@(posedge clk) disable iff (rst)
        $fell(ram_inh_o) |-> sfr_rst_o);

    a_r6_cpu_runs_in_window: assert property (@(posedge clk) disable iff (rst)
        ram_inh_o |-> cpu_clk_en_o);

    a_r9_run_reset_direct: assert property (@(posedge clk) disable iff (rst)
        (cpu_clk_en_o && !ram_inh_o && hw_rst_i) |=> (sfr_rst_o && !ram_inh_o));

    a_r5_pdn_stays_dark: assert property (@(posedge clk) disable iff (rst)
        (!osc_en_o && !hw_rst_i) |=> !osc_en_o);

endmodule

// File: tb/sim_lpm_ctrl.sv
`timescale 1ns/1ps
module sim_lpm_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hw_rst_i = 1'b0, irq_pend_i = 1'b0, osc_stable_i = 1'b1;
    logic       ctl_wr_i = 1'b0;
    logic [1:0] ctl_wdata_i = 2'b00;
    logic       cpu_clk_en_o, per_clk_en_o, osc_en_o, sfr_rst_o, ram_inh_o;
    logic [1:0] req_bits_o;

    int checks = 0;
    int bad    = 0;
    int port_wr = 0;
    int ram_wr  = 0;

    always #4 clk = ~clk;

    lpm_ctrl u0 (.*);

    // CPU stub: one port write and one RAM write attempt per enabled cycle
    always @(posedge clk) begin
        if (!rst && cpu_clk_en_o) begin
            port_wr = port_wr + 1;
            if (!ram_inh_o) ram_wr = ram_wr + 1;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] d);
        ctl_wr_i = 1'b1; ctl_wdata_i = d;
        tick(1);
        ctl_wr_i = 1'b0; ctl_wdata_i = 2'b00;
    endtask

    task automatic t_reset_state;
        chk("R1", "cpu_en", cpu_clk_en_o, 1);
        chk("R1", "per_en", per_clk_en_o, 1);
        chk("R1", "osc_en", osc_en_o, 1);
        chk("R1", "ram_inh", ram_inh_o, 0);
        chk("R1", "sfr_rst", sfr_rst_o, 0);
        chk("R1", "bits", req_bits_o, 0);
    endtask

    task automatic t_idle_irq;
        wr(2'b01);
        chk("R2", "cpu_en", cpu_clk_en_o, 0);
        chk("R2", "per_en", per_clk_en_o, 1);
        chk("R2", "osc_en", osc_en_o, 1);
        chk("R2", "bits", req_bits_o, 1);
        tick(3);
        chk("R2", "still idle", cpu_clk_en_o, 0);
        irq_pend_i = 1'b1; tick(1); irq_pend_i = 1'b0;
        chk("R3", "cpu_en", cpu_clk_en_o, 1);
        chk("R3", "bits", req_bits_o, 0);
        chk("R3", "sfr_rst", sfr_rst_o, 0);
    endtask

    task automatic t_write_in_idle;
        wr(2'b01);
        wr(2'b10);
        chk("R10", "bits", req_bits_o, 1);
        chk("R10", "osc_en", osc_en_o, 1);
        irq_pend_i = 1'b1; tick(1); irq_pend_i = 1'b0;
        chk("R10", "back to run", cpu_clk_en_o, 1);
    endtask

    task automatic t_pdn_prio_irq;
        wr(2'b11);
        chk("R4", "cpu_en", cpu_clk_en_o, 0);
        chk("R4", "per_en", per_clk_en_o, 0);
        chk("R4", "osc_en", osc_en_o, 0);
        chk("R4", "bits", req_bits_o, 2);
        irq_pend_i = 1'b1; tick(4); irq_pend_i = 1'b0;
        chk("R5", "osc_en", osc_en_o, 0);
        chk("R5", "cpu_en", cpu_clk_en_o, 0);
        chk("R5", "bits", req_bits_o, 2);
    endtask

    task automatic t_pdn_wake;
        osc_stable_i = 1'b0;
        hw_rst_i = 1'b1; tick(1);
        chk("R7", "osc_en on wake", osc_en_o, 1);
        chk("R7", "cpu_en on wake", cpu_clk_en_o, 0);
        hw_rst_i = 1'b0; tick(1);
        chk("R7", "fall back osc_en", osc_en_o, 0);
        hw_rst_i = 1'b1; tick(3);
        chk("R7", "osc_en waiting", osc_en_o, 1);
        chk("R7", "no pulse before stable", sfr_rst_o, 0);
        osc_stable_i = 1'b1; tick(1);
        chk("R8", "pulse", sfr_rst_o, 1);
        chk("R8", "bits cleared", req_bits_o, 0);
        tick(1);
        chk("R8", "pulse one cycle", sfr_rst_o, 0);
        chk("R8", "cpu held", cpu_clk_en_o, 0);
        hw_rst_i = 1'b0; tick(1);
        chk("R8", "cpu resumes", cpu_clk_en_o, 1);
    endtask

    task automatic t_idle_hwrst;
        int n = 0;
        int p0, r0;
        wr(2'b01);
        p0 = port_wr; r0 = ram_wr;
        hw_rst_i = 1'b1; tick(1);
        while (ram_inh_o && n < 100) begin
            chk("R6", "cpu_en in window", cpu_clk_en_o, 1);
            n++;
            tick(1);
        end
        chk("R6", "window length", n, 24);
        chk("R6", "port writes in window", port_wr - p0, 24);
        chk("R6", "ram writes in window", ram_wr - r0, 0);
        chk("R6", "pulse after window", sfr_rst_o, 1);
        chk("R6", "cpu stopped", cpu_clk_en_o, 0);
        hw_rst_i = 1'b0; tick(1);
        chk("R8", "run after release", cpu_clk_en_o, 1);
        chk("R8", "bits", req_bits_o, 0);
    endtask

    task automatic t_run_hwrst;
        hw_rst_i = 1'b1; tick(1);
        chk("R9", "pulse", sfr_rst_o, 1);
        chk("R9", "no inhibit", ram_inh_o, 0);
        chk("R9", "cpu_en", cpu_clk_en_o, 0);
        tick(2);
        chk("R8", "single pulse", sfr_rst_o, 0);
        hw_rst_i = 1'b0; tick(1);
        chk("R9", "cpu resumes", cpu_clk_en_o, 1);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        tick(2);
        rst = 1'b0;
        tick(1);
        t_reset_state();
        t_idle_irq();
        t_write_in_idle();
        t_pdn_prio_irq();
        t_pdn_wake();
        t_idle_hwrst();
        t_run_hwrst();
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule